// File: doc/BRIEF.md
# Bus-Organized General Register Datapath

This block is the execute slice of a small processor: seven general-purpose registers share two source buses, an ALU and a result bus. A control unit elsewhere supplies one packed 14-bit control word each clock. The word names the register (or the external input port) that drives each of the ALU's two source buses, the ALU function, and the register that receives the result. There is no instruction fetch, sequencing or microprogram store inside the block. Each cycle is one complete micro-operation such as "R1 gets R2 minus R3" or "R5 gets zero".

The ALU result and its status flags are always visible on the output ports, in the same cycle as the control word that produced them. The write into the destination register takes place on the next rising clock edge, and only when the valid strobe is high. Destination code zero discards the result, which makes it possible to move data to the output port without disturbing any register.

Top module: `reg_bus_datapath`

## Requirements
- R1: The control word is split as source A select in bits 13:11, source B select in bits 10:8, destination select in bits 7:5 and operation code in bits 4:0. Select codes 1 to 7 name registers R1 to R7 on all three selectors.
- R2: Select code 0 on source A or source B places `ext_in` on that bus. A control word of all zeros drives `ext_in` to `out_data` unchanged.
- R3: The destination register is written on the rising clock edge only when `valid` is high and the destination code is nonzero. Destination code 0, or `valid` low, leaves every register unchanged.
- R4: `out_data` always carries the ALU result of the current control word, combinationally, whether or not a write occurs.
- R5: A synchronous active-high `rst` clears all seven registers to zero, and reset takes priority over a write in the same cycle.
- R6: The arithmetic operation codes are 00000 pass A, 00001 A+1, 00010 A+B, 00101 A−B and 00110 A−1. All results wrap modulo 2^WIDTH.
- R7: The logic operation codes are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A. XOR of a register with itself clears that register.
- R8: Code 10000 shifts A right by one and code 11000 shifts A left by one. The vacated bit is filled with 0, and the carry flag takes the bit that is shifted out.
- R9: `flag_zero` is high when the result is all zeros. `flag_neg` equals the result's most significant bit.
- R10: `flag_carry` is the carry-out for add and increment. It is the no-borrow indication (high when no borrow occurs) for subtract and decrement. It is 0 for pass, logic and illegal operations.
- R11: `flag_ovf` flags two's-complement overflow for add, subtract, increment and decrement, and is 0 for all other operations.
- R12: Any operation code not listed in R6 to R8 produces a zero result, raises `flag_illegal` for that cycle and leaves carry and overflow at 0. The zero result is still written when R3 permits a write.
- R13: Pass, increment, decrement, NOT and both shifts do not depend on the source B select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the register set |
| ctrl_word | input | 14 | Packed micro-operation: source A, source B, destination, operation |
| ext_in | input | WIDTH | External data, selected by source code 0 |
| valid | input | 1 | Enables the write-back of the current micro-operation |
| out_data | output | WIDTH | ALU result of the current control word |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result most significant bit |
| flag_carry | output | 1 | Carry-out / no-borrow / shifted-out bit |
| flag_ovf | output | 1 | Signed overflow |
| flag_illegal | output | 1 | Operation code not recognised |

## Verification
The bench builds the block at its default width of 8 bits. At that width the carry and overflow boundaries are the values 0xFF, 0x7F and 0x80, which directed stimulus hits exactly. A few hundred random micro-operations also sweep a large share of the operand space against the behavioural model. All 32 operation codes are driven, so every unlisted code is seen at least once. A mid-run reset shows that reset takes priority over a write requested in the same cycle.

// File: rtl/gpr_dp_pkg.sv
package gpr_dp_pkg;

    localparam int SEL_W  = 3;
    localparam int OPR_W  = 5;
    localparam int CW_W   = 3 * SEL_W + OPR_W;
    localparam int NUM_GP = (1 << SEL_W) - 1;

    typedef enum logic [OPR_W-1:0] {
        OP_PASS_A = 5'b00000,
        OP_INC_A  = 5'b00001,
        OP_ADD    = 5'b00010,
        OP_SUB    = 5'b00101,
        OP_DEC_A  = 5'b00110,
        OP_AND    = 5'b01000,
        OP_OR     = 5'b01010,
        OP_XOR    = 5'b01100,
        OP_NOT_A  = 5'b01110,
        OP_SHR_A  = 5'b10000,
        OP_SHL_A  = 5'b11000
    } alu_op_e;

    // Field order is fixed: source A is the most significant field.
    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OPR_W-1:0] opr;
    } ctrl_word_t;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
        logic illegal;
    } alu_flags_t;

    function automatic logic op_is_known(logic [OPR_W-1:0] code);
        case (code)
            OP_PASS_A, OP_INC_A, OP_ADD, OP_SUB, OP_DEC_A,
            OP_AND, OP_OR, OP_XOR, OP_NOT_A, OP_SHR_A, OP_SHL_A:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [W-1:0]                wr_data,
    output logic [NUM_GP:1]             wr_hit,
    output logic [NUM_GP:1][W-1:0]      regs_q
);

    for (genvar g = 1; g <= NUM_GP; g++) begin : g_reg
        assign wr_hit[g] = wr_en && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_hit[g]) begin
                regs_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/bus_src_mux.sv
module bus_src_mux
    import gpr_dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [SEL_W-1:0]            sel,
    input  logic [W-1:0]                ext_in,
    input  logic [NUM_GP:1][W-1:0]      regs_q,
    output logic [W-1:0]                bus
);

    always_comb begin
        bus = ext_in;
        for (int i = 1; i <= NUM_GP; i++) begin
            if (sel == SEL_W'(i)) begin
                bus = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import gpr_dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [OPR_W-1:0]  opr,
    output logic [W-1:0]      result,
    output alu_flags_t        flags
);

    localparam int MSB = W - 1;

    logic [W:0]   sum_ext;
    logic [W-1:0] addend;
    logic         cin;
    logic         use_adder;
    logic         signed_op;

    // One shared adder serves add, subtract, increment and decrement.
    always_comb begin
        use_adder = 1'b1;
        addend    = b;
        cin       = 1'b0;
        case (opr)
            OP_INC_A: begin addend = '0;  cin = 1'b1; end
            OP_ADD:   begin addend = b;   cin = 1'b0; end
            OP_SUB:   begin addend = ~b;  cin = 1'b1; end
            OP_DEC_A: begin addend = '1;  cin = 1'b0; end
            default:  use_adder = 1'b0;
        endcase
        sum_ext = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cin};
    end

    always_comb begin
        result        = '0;
        flags.carry   = 1'b0;
        flags.illegal = 1'b0;
        signed_op     = 1'b0;
        if (use_adder) begin
            result      = sum_ext[W-1:0];
            flags.carry = sum_ext[W];
            signed_op   = 1'b1;
        end else begin
            case (opr)
                OP_PASS_A: result = a;
                OP_AND:    result = a & b;
                OP_OR:     result = a | b;
                OP_XOR:    result = a ^ b;
                OP_NOT_A:  result = ~a;
                OP_SHR_A: begin
                    result      = {1'b0, a[MSB:1]};
                    flags.carry = a[0];
                end
                OP_SHL_A: begin
                    result      = {a[MSB-1:0], 1'b0};
                    flags.carry = a[MSB];
                end
                default:   flags.illegal = 1'b1;
            endcase
        end
        // Signed overflow: both adder operands agree in sign, result differs.
        flags.ovf  = signed_op && (a[MSB] == addend[MSB]) && (result[MSB] != a[MSB]);
        flags.zero = (result == '0);
        flags.neg  = result[MSB];
    end

endmodule

// File: rtl/reg_bus_datapath.sv
module reg_bus_datapath
    import gpr_dp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [WIDTH-1:0]  ext_in,
    input  logic              valid,
    output logic [WIDTH-1:0]  out_data,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              flag_carry,
    output logic              flag_ovf,
    output logic              flag_illegal
);

    ctrl_word_t                       cw;
    logic [NUM_GP:1][WIDTH-1:0]       regs_q;
    logic [NUM_GP:1]                  wr_hit;
    logic [WIDTH-1:0]                 bus_a;
    logic [WIDTH-1:0]                 bus_b;
    logic [WIDTH-1:0]                 alu_res;
    alu_flags_t                       alu_flg;
    logic                             wb_en;

    assign cw    = ctrl_word_t'(ctrl_word);
    assign wb_en = valid && (cw.dst != '0);

    bus_src_mux #(.W(WIDTH)) u_mux_a (
        .sel    (cw.src_a),
        .ext_in (ext_in),
        .regs_q (regs_q),
        .bus    (bus_a)
    );

    bus_src_mux #(.W(WIDTH)) u_mux_b (
        .sel    (cw.src_b),
        .ext_in (ext_in),
        .regs_q (regs_q),
        .bus    (bus_b)
    );

    alu_core #(.W(WIDTH)) u_alu (
        .a      (bus_a),
        .b      (bus_b),
        .opr    (cw.opr),
        .result (alu_res),
        .flags  (alu_flg)
    );

    gpr_bank #(.W(WIDTH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wb_en),
        .wr_sel  (cw.dst),
        .wr_data (alu_res),
        .wr_hit  (wr_hit),
        .regs_q  (regs_q)
    );

    assign out_data     = alu_res;
    assign flag_zero    = alu_flg.zero;
    assign flag_neg     = alu_flg.neg;
    assign flag_carry   = alu_flg.carry;
    assign flag_ovf     = alu_flg.ovf;
    assign flag_illegal = alu_flg.illegal;

endmodule

// File: rtl/gpr_dp_checker.sv
module gpr_dp_checker
    import gpr_dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [W-1:0]      ext_in,
    input  logic              valid,
    input  logic [W-1:0]      out_data,
    input  logic              flag_zero,
    input  logic              flag_carry,
    input  logic              flag_ovf,
    input  logic              flag_illegal,
    input  logic [NUM_GP:1]   wr_hit
);

    logic [SEL_W-1:0] f_a;
    logic [SEL_W-1:0] f_d;
    logic [OPR_W-1:0] f_op;

    assign f_a  = ctrl_word[13:11];
    assign f_d  = ctrl_word[7:5];
    assign f_op = ctrl_word[4:0];

    // R3
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit));

    // R3
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid || f_d == '0) |-> (wr_hit == '0));

    // R3
    writeback_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid) && $past(f_d) != '0 &&
         f_a == $past(f_d) && f_op == 5'b00000)
        |-> (out_data == $past(out_data)));

    // R2
    pass_input_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word == '0) |-> (out_data == ext_in && !flag_illegal));

    // R5
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && f_a != '0 && f_op == 5'b00000) |-> (out_data == '0));

    // R12
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flag_illegal |-> (out_data == '0 && flag_zero && !flag_carry && !flag_ovf));

endmodule

bind reg_bus_datapath gpr_dp_checker #(.W(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_word    (ctrl_word),
    .ext_in       (ext_in),
    .valid        (valid),
    .out_data     (out_data),
    .flag_zero    (flag_zero),
    .flag_carry   (flag_carry),
    .flag_ovf     (flag_ovf),
    .flag_illegal (flag_illegal),
    .wr_hit       (wr_hit)
);

// File: tb/test_reg_bus_datapath.sv
`timescale 1ns/1ps
module test_reg_bus_datapath;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ctrl_word = '0;
    logic [7:0]  ext_in = '0;
    logic        valid = 1'b0;
    logic [7:0]  out_data;
    logic        flag_zero, flag_neg, flag_carry, flag_ovf, flag_illegal;

    int errors = 0;
    int checks = 0;
    int model_regs [1:7];
    bit done = 0;

    always #2.5 clk = ~clk;

    reg_bus_datapath #(.WIDTH(8)) i_reg_bus_datapath (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
        .valid(valid), .out_data(out_data), .flag_zero(flag_zero),
        .flag_neg(flag_neg), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
        .flag_illegal(flag_illegal)
    );

    // Behavioural reference: returns {illegal, zero, neg, carry, ovf, result[7:0]}
    function automatic logic [12:0] ref_alu(int a, int b, int op);
        int s = 0, r = 0, c = 0, v = 0, ill = 0;
        case (op)
            0:  r = a;
            1:  begin s = a + 1;   r = s % 256; c = s / 256; v = (a == 127); end
            2:  begin s = a + b;   r = s % 256; c = s / 256;
                      v = (a < 128 && b < 128 && r >= 128) || (a >= 128 && b >= 128 && r < 128); end
            5:  begin r = (a - b + 256) % 256; c = (a >= b);
                      v = (a < 128 && b >= 128 && r >= 128) || (a >= 128 && b < 128 && r < 128); end
            6:  begin r = (a + 255) % 256; c = (a != 0); v = (a == 128); end
            8:  r = a & b;
            10: r = a | b;
            12: r = a ^ b;
            14: r = 255 - a;
            16: begin r = a / 2; c = a % 2; end
            24: begin r = (a * 2) % 256; c = a / 128; end
            default: ill = 1;
        endcase
        return {ill[0], (r == 0), (r >= 128), c[0], v[0], 8'(r)};
    endfunction

    task automatic step(input int sa, input int sb, input int sd, input int op,
                        input int x, input bit v, input string tag);
        int a, b;
        logic [12:0] e;
        logic [12:0] got;
        @(negedge clk);
        ctrl_word = {3'(sa), 3'(sb), 3'(sd), 5'(op)};
        ext_in    = 8'(x);
        valid     = v;
        #1;
        a = (sa == 0) ? x : model_regs[sa];
        b = (sb == 0) ? x : model_regs[sb];
        e = ref_alu(a, b, op);
        got = {flag_illegal, flag_zero, flag_neg, flag_carry, flag_ovf, out_data};
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: cw=%b in=%h got {ill,z,n,c,v,res}=%b expected %b",
                     tag, ctrl_word, ext_in, got, e);
        end
        @(posedge clk);
        if (v && sd != 0) model_regs[sd] = int'(e[7:0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        valid = 1'b1;
        ctrl_word = {3'd0, 3'd0, 3'd4, 5'd0};
        ext_in = 8'h99;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        valid = 1'b0;
        for (int k = 1; k <= 7; k++) model_regs[k] = 0;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int vals [1:7] = '{8'h7F, 8'h05, 8'h03, 8'hF0, 8'h0F, 8'hFF, 8'h80};
        int legal [0:10] = '{0, 1, 2, 5, 6, 8, 10, 12, 14, 16, 24};
        for (int k = 1; k <= 7; k++) model_regs[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R5: every register reads zero after reset
        for (int k = 1; k <= 7; k++) step(k, 0, 0, 0, 8'hEE, 1, "R5");
        // R2: load from external input, R1 register codes
        for (int k = 1; k <= 7; k++) step(0, 0, k, 0, vals[k], 1, "R2");
        for (int k = 1; k <= 7; k++) step(k, 0, 0, 0, 0, 0, "R1");
        // Example micro-operations
        step(2, 3, 1, 5, 0, 1, "R6");      // R1 <- R2 - R3
        step(1, 0, 0, 0, 0, 0, "R1");
        step(4, 5, 4, 10, 0, 1, "R7");     // R4 <- R4 | R5
        step(6, 0, 6, 1, 0, 1, "R10");     // R6 <- R6 + 1, 0xFF wraps
        step(1, 0, 7, 0, 0, 1, "R4");      // R7 <- R1
        step(2, 0, 0, 0, 0, 1, "R4");      // output <- R2
        step(0, 0, 0, 0, 8'h3C, 1, "R2");  // output <- input
        step(4, 0, 4, 24, 0, 1, "R8");     // R4 <- shl R4
        step(5, 5, 5, 12, 0, 1, "R7");     // R5 <- 0
        step(5, 0, 0, 0, 0, 0, "R9");
        // Carry, borrow and overflow corners
        step(0, 0, 1, 0, 8'h7F, 1, "R2");
        step(0, 0, 3, 0, 8'h01, 1, "R2");
        step(1, 3, 2, 2, 0, 1, "R11");     // 0x7F + 1
        step(0, 3, 0, 5, 8'h80, 0, "R11"); // 0x80 - 1
        step(0, 3, 0, 5, 8'h00, 0, "R10"); // borrow
        step(0, 3, 0, 5, 8'h01, 0, "R10"); // equal, no borrow
        step(0, 0, 0, 6, 8'h00, 0, "R10");
        step(0, 0, 0, 6, 8'h80, 0, "R11");
        step(0, 0, 0, 1, 8'h7F, 0, "R11");
        step(0, 0, 0, 2, 8'hFF, 0, "R10");
        step(0, 0, 0, 16, 8'h81, 0, "R8");
        step(0, 0, 0, 24, 8'h81, 0, "R8");
        step(0, 0, 0, 14, 8'h5A, 0, "R7");
        step(0, 3, 0, 8, 8'hFF, 0, "R7");
        step(0, 0, 0, 0, 8'h00, 0, "R9");
        // R13: source B select has no effect on single-operand ops
        for (int s = 0; s <= 7; s++) step(0, s, 0, 1, 8'h33, 0, "R13");
        for (int s = 0; s <= 7; s++) step(0, s, 0, 24, 8'hC3, 0, "R13");
        for (int s = 0; s <= 7; s++) step(0, s, 0, 6, 8'h10, 0, "R13");
        // R3: valid low and destination zero leave registers alone
        step(0, 0, 2, 0, 8'hAA, 0, "R3");
        step(2, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 8'h55, 1, "R3");
        for (int k = 1; k <= 7; k++) step(k, 0, 0, 0, 0, 0, "R3");
        // R12: every unlisted code
        for (int c = 0; c < 32; c++) begin
            bit known = 0;
            foreach (legal[j]) if (legal[j] == c) known = 1;
            if (!known) begin
                step(0, 0, 1, 0, 8'h5C, 1, "R12");
                step(0, 0, 1, c, 8'h5C, 1, "R12");
                step(1, 0, 0, 0, 0, 0, "R12");
            end
        end
        // R5: reset wins over a write in the same cycle
        for (int k = 1; k <= 7; k++) step(0, 0, k, 0, 8'h40 + k, 1, "R2");
        do_reset();
        for (int k = 1; k <= 7; k++) step(k, 0, 0, 0, 0, 0, "R5");
        // Random micro-operations against the model
        for (int n = 0; n < 600; n++) begin
            int op = legal[$urandom_range(0, 10)];
            if ($urandom_range(0, 7) == 0) op = int'($urandom_range(0, 31));
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), op, int'($urandom_range(0, 255)),
                 bit'($urandom_range(0, 3) != 0), "R6");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule